// File: doc/BRIEF.md
# I/O Page-Table Entry Fault Checker

This block sits in a device DMA address path. For each request it takes one 32-bit I/O page-table entry that has already been fetched, the device virtual address and the access direction. It returns either a translated physical address or a fault. Each fault is recorded in a fault status word and a fault address word. The host reads both through a small word-wide register port, and clears them there too. A per-slot configuration word, on the same port, can switch the path to bypass. In bypass the device address is used as the physical address and one forced upper bit is applied.

A request is presented for one cycle with `xl_valid`. The result appears on the `out_*` pins on the next cycle. The fault log is updated on the same clock edge. Host reads are combinational from the stored registers. Host writes take effect at the next clock edge.

Top module: `iopte_fault_checker`

## Requirements
- R1: After reset the fault status reads 0x00800000, the fault address reads 0, the slot configuration reads 0, and `out_valid` is 0.
- R2: For a request that does not fault, outside bypass, the next cycle shows `out_valid`=1 and `out_fault`=0. `out_pa` is {1'b0, entry[26:8], dva[11:0]}, and `out_cacheable` equals entry bit 7.
- R3: A request faults when entry bit 1 (valid) is 0, or when it is a write (`xl_write`=1) and entry bit 2 (writable) is 0. A faulting result shows `out_fault`=1, `out_pa`=0 and `out_cacheable`=0. A read of a valid entry whose writable bit is clear does not fault.
- R4: On a fault while status bit 17 is clear, the status becomes 0xC0820000. Bit 18 is added for a read, `xl_size` goes into bits 27:25 and `xl_priv` into bit 24. The fault address register takes the request's device address.
- R5: On a fault while status bit 17 is set, status bit 19 is set, the other status bits are kept, and the fault address register is left unchanged.
- R6: A host write of 0 to register 0 returns the status to 0x00800000 and leaves the fault address unchanged. A nonzero write to register 0 has no effect, and a write to register 1 has no effect.
- R7: Register 2 is the slot configuration. Only bits 0, 1, 2 and 16 are stored, and all other bits read 0. Register 3 reads 0.
- R8: With configuration bit 0 set, a request never faults. `out_pa` is {1'b0, configuration bit 16, dva[29:0]}, `out_cacheable` is 0, and the fault registers do not change.
- R9: If a host clear and a fault happen in the same cycle, the fault is logged as a first fault (R4 value, bit 19 clear, new address captured).
- R10: In a cycle that follows one without `xl_valid`, `out_valid` is 0 and the fault registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_valid | input | 1 | Request strobe |
| xl_pte | input | 32 | Page-table entry for the request |
| xl_dva | input | 32 | Device virtual address |
| xl_write | input | 1 | 1 = write access, 0 = read |
| xl_size | input | 3 | Transfer size code, logged on a fault |
| xl_priv | input | 1 | Supervisor-mode flag, logged on a fault |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_pa | output | 32 | Physical address, or 0 on a fault |
| out_fault | output | 1 | Request faulted |
| out_cacheable | output | 1 | Entry's cacheable flag for a good translation |
| host_addr | input | 2 | Register select: 0 status, 1 fault address, 2 slot configuration |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |

## Verification
The hardest states to reach from the ports are the collisions in the fault log. One is a second fault that lands while the first is still pending. The other is a host clear that lands in the same cycle as a new fault. The bench reaches the first by issuing two faulting requests with no clear between them. It reaches the second by raising the clear write and a faulting request on the same falling edge, so both are sampled at one rising edge. In both cases it reads the status and address words back before doing anything else. The main sweep covers every combination of valid flag, writable flag and direction over several page numbers, with a clear before each request so that each fault word can be predicted on its own.

// File: rtl/iopte_pkg.sv
package iopte_pkg;

    localparam int WORD_W    = 32;
    localparam int HOST_AW   = 2;
    localparam int OFF_W     = 12;
    localparam int PAGE_LSB  = 8;
    localparam int PAGE_MSB  = 26;
    localparam int PAGE_W    = PAGE_MSB - PAGE_LSB + 1;
    localparam int SIZE_W    = 3;

    // entry flag positions
    localparam int ENT_VALID = 1;
    localparam int ENT_WRITE = 2;
    localparam int ENT_CACHE = 7;

    // fault status bit positions
    localparam int FS_ERR    = 31;
    localparam int FS_LATE   = 30;
    localparam int FS_SIZE_L = 25;
    localparam int FS_PRIV   = 24;
    localparam int FS_MULTI  = 19;
    localparam int FS_READ   = 18;
    localparam int FS_AVALID = 17;

    localparam logic [WORD_W-1:0] FS_RESET  = 32'h0080_0000;
    localparam logic [WORD_W-1:0] CFG_KEEP  = 32'h0001_0007;
    localparam int CFG_BYPASS = 0;
    localparam int CFG_A30    = 16;

    typedef enum logic [HOST_AW-1:0] {
        HR_FSTAT = 2'd0,
        HR_FADDR = 2'd1,
        HR_SLOT  = 2'd2,
        HR_SPARE = 2'd3
    } host_reg_e;

    typedef struct packed {
        logic [WORD_W-1:0] ent;
        logic [WORD_W-1:0] dva;
        logic              wr;
        logic [SIZE_W-1:0] size;
        logic              priv;
    } xl_req_t;

    typedef struct packed {
        logic [WORD_W-1:0] pa;
        logic              fault;
        logic              cacheable;
    } xl_rsp_t;

    function automatic logic [WORD_W-1:0] first_fault_word(
        input logic              is_read,
        input logic [SIZE_W-1:0] size,
        input logic              priv
    );
        logic [WORD_W-1:0] w;
        w = FS_RESET;
        w[FS_ERR]    = 1'b1;
        w[FS_LATE]   = 1'b1;
        w[FS_AVALID] = 1'b1;
        w[FS_READ]   = is_read;
        w[FS_SIZE_L +: SIZE_W] = size;
        w[FS_PRIV]   = priv;
        return w;
    endfunction

endpackage

// File: rtl/iopte_decode.sv
module iopte_decode
    import iopte_pkg::*;
(
    input  xl_req_t req,
    input  logic    bypass,
    input  logic    bypass_a30,
    output xl_rsp_t rsp
);
    logic bad_valid;
    logic bad_write;

    always_comb begin
        bad_valid = ~req.ent[ENT_VALID];
        bad_write = req.wr & ~req.ent[ENT_WRITE];
        rsp = '0;
        if (bypass) begin
            rsp.pa = {1'b0, bypass_a30, req.dva[WORD_W-3:0]};
        end else if (bad_valid | bad_write) begin
            rsp.fault = 1'b1;
        end else begin
            rsp.pa        = {1'b0, req.ent[PAGE_MSB:PAGE_LSB], req.dva[OFF_W-1:0]};
            rsp.cacheable = req.ent[ENT_CACHE];
        end
    end
endmodule

// File: rtl/iopte_fault_log.sv
module iopte_fault_log
    import iopte_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic [WORD_W-1:0] evt_dva,
    input  logic              evt_read,
    input  logic [SIZE_W-1:0] evt_size,
    input  logic              evt_priv,
    input  logic              clr,
    output logic [WORD_W-1:0] stat,
    output logic [WORD_W-1:0] faddr
);
    logic [WORD_W-1:0] base, stat_n, faddr_n;

    always_comb begin
        base    = clr ? FS_RESET : stat;
        stat_n  = base;
        faddr_n = faddr;
        if (evt) begin
            if (base[FS_AVALID]) begin
                stat_n[FS_MULTI] = 1'b1;
            end else begin
                stat_n  = first_fault_word(evt_read, evt_size, evt_priv);
                faddr_n = evt_dva;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat  <= FS_RESET;
            faddr <= '0;
        end else begin
            stat  <= stat_n;
            faddr <= faddr_n;
        end
    end
endmodule

// File: rtl/iopte_slot_cfg.sv
module iopte_slot_cfg
    import iopte_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cfg
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (we) cfg <= wdata & CFG_KEEP;
    end
endmodule

// File: rtl/iopte_fault_checker.sv
module iopte_fault_checker
    import iopte_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        xl_valid,
    input  logic [31:0] xl_pte,
    input  logic [31:0] xl_dva,
    input  logic        xl_write,
    input  logic [2:0]  xl_size,
    input  logic        xl_priv,
    output logic        out_valid,
    output logic [31:0] out_pa,
    output logic        out_fault,
    output logic        out_cacheable,
    input  logic [1:0]  host_addr,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata
);
    xl_req_t           req;
    xl_rsp_t           rsp;
    logic [WORD_W-1:0] stat_q, faddr_q, cfg_q;
    logic              host_clr, cfg_we;
    host_reg_e         hsel;

    assign req      = '{ent: xl_pte, dva: xl_dva, wr: xl_write, size: xl_size, priv: xl_priv};
    assign hsel     = host_reg_e'(host_addr);
    assign host_clr = host_wr && (hsel == HR_FSTAT) && (host_wdata == '0);
    assign cfg_we   = host_wr && (hsel == HR_SLOT);

    iopte_decode u_dec (
        .req        (req),
        .bypass     (cfg_q[CFG_BYPASS]),
        .bypass_a30 (cfg_q[CFG_A30]),
        .rsp        (rsp)
    );

    iopte_fault_log u_log (
        .clk      (clk),
        .rst      (rst),
        .evt      (xl_valid & rsp.fault),
        .evt_dva  (xl_dva),
        .evt_read (~xl_write),
        .evt_size (xl_size),
        .evt_priv (xl_priv),
        .clr      (host_clr),
        .stat     (stat_q),
        .faddr    (faddr_q)
    );

    iopte_slot_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (host_wdata),
        .cfg   (cfg_q)
    );

    always_ff @(posedge clk) begin
        if (rst || !xl_valid) begin
            out_valid     <= 1'b0;
            out_pa        <= '0;
            out_fault     <= 1'b0;
            out_cacheable <= 1'b0;
        end else begin
            out_valid     <= 1'b1;
            out_pa        <= rsp.pa;
            out_fault     <= rsp.fault;
            out_cacheable <= rsp.cacheable;
        end
    end

    always_comb begin
        unique case (hsel)
            HR_FSTAT: host_rdata = stat_q;
            HR_FADDR: host_rdata = faddr_q;
            HR_SLOT:  host_rdata = cfg_q;
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/iopte_checker.sv
module iopte_checker (
    input logic        clk,
    input logic        rst,
    input logic        xl_valid,
    input logic        host_clr,
    input logic        out_valid,
    input logic        out_fault,
    input logic [31:0] out_pa,
    input logic [31:0] stat_q,
    input logic [31:0] faddr_q,
    input logic [31:0] cfg_q
);
    p_fault_zero_pa_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fault) |-> (out_pa == 32'h0));

    p_pa_top_clear_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_pa[31] == 1'b0));

    p_reserved_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (stat_q[23:20] == 4'h8) && (stat_q[17] == stat_q[31]));

    p_multi_needs_prior_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[19]) |-> $past(stat_q[17]));

    p_addr_held_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_q[17] && $past(stat_q[17]) && !$past(host_clr)) |-> $stable(faddr_q));

    p_bypass_no_fault_r8: assert property (@(posedge clk) disable iff (rst)
        (xl_valid && cfg_q[0]) |=> !out_fault);

    p_idle_no_result_r10: assert property (@(posedge clk) disable iff (rst)
        !xl_valid |=> !out_valid);
endmodule

bind iopte_fault_checker iopte_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .xl_valid  (xl_valid),
    .host_clr  (host_clr),
    .out_valid (out_valid),
    .out_fault (out_fault),
    .out_pa    (out_pa),
    .stat_q    (stat_q),
    .faddr_q   (faddr_q),
    .cfg_q     (cfg_q)
);

// File: tb/tb_iopte_fault_checker.sv
module tb_iopte_fault_checker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xl_valid = 1'b0;
    logic [31:0] xl_pte = '0;
    logic [31:0] xl_dva = '0;
    logic        xl_write = 1'b0;
    logic [2:0]  xl_size = '0;
    logic        xl_priv = 1'b0;
    logic        out_valid, out_fault, out_cacheable;
    logic [31:0] out_pa, host_rdata;
    logic [1:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    iopte_fault_checker dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fault_word(input bit wr, input logic [2:0] sz, input bit pv);
        return 32'hC082_0000 | (wr ? 32'h0 : 32'h0004_0000) | (32'(sz) << 25) | (32'(pv) << 24);
    endfunction

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] e, input logic [31:0] d, input bit w,
                         input logic [2:0] sz, input bit pv);
        @(negedge clk);
        xl_valid = 1'b1; xl_pte = e; xl_dva = d; xl_write = w; xl_size = sz; xl_priv = pv;
        @(negedge clk);
        xl_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, e, d, a1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", {31'b0, out_valid}, 32'h0);
        rd(2'd0, v); chk("R1 status", v, 32'h0080_0000);
        rd(2'd1, v); chk("R1 faddr", v, 32'h0);
        rd(2'd2, v); chk("R1 cfg", v, 32'h0);

        // R2/R3/R4 sweep over flag and direction combinations
        for (int f = 0; f < 4; f++) begin
            for (int w = 0; w < 2; w++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [18:0] pg;
                    bit vb, wb, c, flt;
                    logic [2:0] sz;
                    vb = f[0]; wb = f[1];
                    pg = 19'(32'h1_2345 * (k + 1) + f * 7);
                    c  = k[0];
                    sz = 3'(k + f);
                    e  = {5'b0, pg, c, 4'b0, wb, vb, 1'b0};
                    d  = 32'hA5C0_0000 + 32'(k * 32'h1357) + 32'(f * 16 + w);
                    flt = !vb || (w == 1 && !wb);
                    wr_reg(2'd0, 32'h0);
                    xlate(e, d, w[0], sz, k[1]);
                    chk("R2 out_valid", {31'b0, out_valid}, 32'h1);
                    chk("R3 out_fault", {31'b0, out_fault}, {31'b0, flt});
                    chk("R2 out_pa", out_pa, flt ? 32'h0 : {1'b0, pg, d[11:0]});
                    chk("R2 cacheable", {31'b0, out_cacheable}, flt ? 32'h0 : {31'b0, c});
                    rd(2'd0, v);
                    chk("R4 status", v, flt ? fault_word(w[0], sz, k[1]) : 32'h0080_0000);
                    if (flt) begin
                        rd(2'd1, v); chk("R4 faddr", v, d);
                    end
                end
            end
        end

        // R10 idle cycle
        @(negedge clk);
        chk("R10 out_valid idle", {31'b0, out_valid}, 32'h0);

        // R5 second fault
        wr_reg(2'd0, 32'h0);
        a1 = 32'h0000_1ABC;
        xlate(32'h0, a1, 1'b0, 3'd2, 1'b1);
        xlate(32'h0000_0002, 32'h0000_2DEF, 1'b1, 3'd5, 1'b0);
        rd(2'd0, v); chk("R5 multi status", v, fault_word(1'b0, 3'd2, 1'b1) | 32'h0008_0000);
        rd(2'd1, v); chk("R5 faddr kept", v, a1);

        // R6 ignored writes, then clear
        wr_reg(2'd0, 32'h0000_0001);
        rd(2'd0, v); chk("R6 nonzero write ignored", v, fault_word(1'b0, 3'd2, 1'b1) | 32'h0008_0000);
        wr_reg(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R6 faddr write ignored", v, a1);
        wr_reg(2'd0, 32'h0);
        rd(2'd0, v); chk("R6 clear status", v, 32'h0080_0000);
        rd(2'd1, v); chk("R6 clear keeps faddr", v, a1);

        // R9 clear and fault in same cycle
        xlate(32'h0, 32'h0000_0111, 1'b0, 3'd0, 1'b0);
        @(negedge clk);
        host_addr = 2'd0; host_wr = 1'b1; host_wdata = 32'h0;
        xl_valid = 1'b1; xl_pte = 32'h0; xl_dva = 32'h0000_0999; xl_write = 1'b1;
        xl_size = 3'd7; xl_priv = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; xl_valid = 1'b0;
        rd(2'd0, v); chk("R9 status", v, fault_word(1'b1, 3'd7, 1'b1));
        rd(2'd1, v); chk("R9 faddr", v, 32'h0000_0999);

        // R7 configuration
        wr_reg(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R7 cfg mask", v, 32'h0001_0007);
        rd(2'd3, v); chk("R7 spare reads 0", v, 32'h0);

        // R8 bypass
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd2, 32'h0001_0001);
        d = 32'hC123_4567;
        xlate(32'h0000_0080, d, 1'b1, 3'd1, 1'b0);
        chk("R8 no fault", {31'b0, out_fault}, 32'h0);
        chk("R8 pa", out_pa, {2'b01, d[29:0]});
        chk("R8 cacheable", {31'b0, out_cacheable}, 32'h0);
        rd(2'd0, v); chk("R8 status unchanged", v, 32'h0080_0000);
        wr_reg(2'd2, 32'h0000_0001);
        xlate(32'h0, d, 1'b0, 3'd0, 1'b0);
        chk("R8 pa a30 clear", out_pa, {2'b00, d[29:0]});

        // R10 no change to log without request
        @(negedge clk);
        chk("R10 idle valid", {31'b0, out_valid}, 32'h0);
        rd(2'd0, v); chk("R10 status idle", v, 32'h0080_0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule